// File: doc/BRIEF.md
# Control Pin Power Manager

This block turns one general-purpose control pin into the power and frequency controls of a three-PLL clock generator. A static configuration gives the pin one of four roles: frequency select, suspend, output enable or full shutdown. Frequency-select mode can also carry suspend at the same time. The pin is first passed through a two-flop synchronizer. From then on it drives per-output enables for the pad drivers, per-PLL run enables, the reference oscillator and counter enables, and the frequency-select level.

In suspend, a programmed pair of masks names the PLLs and outputs that stop while the pin is low. A consistency check compares the PLL mask with the current crosspoint routing. If a suspended PLL would still feed an output that the output mask does not suspend, the block raises an error flag and ignores the suspend masks.

Each PLL has a lock timer. The timer keeps the PLL's ready flag low until the PLL has been running for a programmable number of reference cycles. An output stays disabled until its source is ready, so after a shutdown or a suspend no output restarts from an unlocked PLL.

Two state machines run the block:
- Power state machine. `PM_ACTIVE` goes to `PM_SHUTDOWN` on the transition *shut request*, which is shutdown mode with the synchronized pin low. `PM_SHUTDOWN` goes back to `PM_ACTIVE` on *shut release*, when that condition clears.
- Lock timer, one per PLL. `LK_OFF` goes to `LK_WAIT` on *start* when the run enable rises, or straight to `LK_READY` when the wait count is zero. `LK_WAIT` goes to `LK_READY` on *lock done* when the count reaches the wait value. Both `LK_WAIT` and `LK_READY` go back to `LK_OFF` on *stop* whenever the run enable drops.

Top module: `pm_ctl_pin`

## Requirements
- R1: The control pin reaches the decode logic through two flops. A level driven on `ctl_pin` before rising edge n is visible at `fs_sel` after edge n+1 and not after edge n.
- R2: `cfg_mode` encodes 0 = frequency select, 1 = suspend, 2 = output enable, 3 = shutdown. `fs_sel` equals the synchronized pin in mode 0 and is 0 in every other mode.
- R3: In mode 2 with the synchronized pin low, all `out_en` bits are 0 and all `pll_run` bits stay 1. Outputs return once the synchronized pin is high again.
- R4: In mode 3 with the synchronized pin low, one edge later `osc_en`, `cnt_en`, all `pll_run` and all `out_en` bits are 0. One further edge later, all `pll_ready` bits are 0.
- R5: In mode 1 with the synchronized pin low and a legal mask, PLL i+1 stops (`pll_run[i]`=0) when `cfg_susp_pll[i]`=1, and output j goes off (`out_en[j]`=0) when `cfg_susp_out[j]`=1. Unmasked PLLs and outputs are unaffected.
- R6: In mode 0 with `cfg_fs_susp`=1, a low synchronized pin applies the suspend masks of R5 and also drives `fs_sel` to 0.
- R7: `cfg_err` is 1 exactly when some output j is routed from PLL k, `cfg_susp_pll[k-1]`=1 and `cfg_susp_out[j]`=0. While it is 1, the suspend masks have no effect.
- R8: `pll_ready[i]` rises at the (W+1)-th consecutive rising edge at which `pll_run[i]` is 1, where W = `cfg_lock_wait`. It is 0 one edge after `pll_run[i]` drops.
- R9: Field `cfg_route[2j+1:2j]` selects the source of output j: 0 = reference, k = 1..3 = PLL k. `out_en[j]` is 0 while its PLL source is not ready. A reference-routed output needs no readiness.
- R10: During and right after reset, the synchronized pin reads high, the power state is active, all `pll_ready` bits are 0 and `osc_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pin | input | 1 | General-purpose control pin, asynchronous |
| cfg_mode | input | 2 | Pin role: 0 FS, 1 suspend, 2 output enable, 3 shutdown |
| cfg_fs_susp | input | 1 | Also apply suspend in frequency-select mode |
| cfg_susp_pll | input | NPLL | PLLs to stop during suspend |
| cfg_susp_out | input | NOUT | Outputs to tri-state during suspend |
| cfg_route | input | NOUT*SEL_W | Crosspoint source of each output |
| cfg_lock_wait | input | LOCK_W | Lock-wait count in reference cycles |
| out_en | output | NOUT | Output driver enable (0 = high impedance) |
| pll_run | output | NPLL | PLL run enable |
| osc_en | output | 1 | Reference oscillator enable |
| cnt_en | output | 1 | Divider counter enable |
| fs_sel | output | 1 | Frequency-select level |
| pll_ready | output | NPLL | PLL locked and usable |
| cfg_err | output | 1 | Suspend mask conflicts with routing |

## Verification
The assertions check the following on every cycle:
- A ready flag only follows a running PLL and clears one edge after the PLL stops.
- No output enable is high while its PLL source is not ready.
- Shutdown clears all readiness.
- Output-enable mode and a flagged mask conflict never stop a PLL.

Only the bench's scenarios can show the rest. That covers the exact synchronizer latency, the one-edge delay into shutdown, the count of W+1 edges before a PLL is ready, and which PLLs and outputs a given suspend mask removes. It also covers FS and suspend acting together from the same pin, and the full relock sequence after shutdown is released.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        PIN_FS   = 2'd0,
        PIN_SUSP = 2'd1,
        PIN_OE   = 2'd2,
        PIN_SHUT = 2'd3
    } pin_mode_e;

    typedef enum logic {
        PM_ACTIVE   = 1'b0,
        PM_SHUTDOWN = 1'b1
    } pm_state_e;

    typedef enum logic [1:0] {
        LK_OFF   = 2'd0,
        LK_WAIT  = 2'd1,
        LK_READY = 2'd2
    } lk_state_e;

endpackage

// File: rtl/pm_sync2.sv
module pm_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            dout   <= RST_VAL;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end

endmodule

// File: rtl/pm_mask_chk.sv
module pm_mask_chk #(
    parameter int NPLL  = 3,
    parameter int NOUT  = 3,
    parameter int SEL_W = 2
) (
    input  logic [NPLL-1:0]       susp_pll,
    input  logic [NOUT-1:0]       susp_out,
    input  logic [NOUT*SEL_W-1:0] route,
    output logic                  err
);

    // An output fed by a suspended PLL must itself be suspended.
    always_comb begin
        err = 1'b0;
        for (int j = 0; j < NOUT; j++) begin
            for (int k = 0; k < NPLL; k++) begin
                if (route[j*SEL_W +: SEL_W] == SEL_W'(k + 1)
                    && susp_pll[k] && !susp_out[j]) begin
                    err = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pm_lock_tmr.sv
module pm_lock_tmr
    import pm_pkg::*;
#(
    parameter int LOCK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [LOCK_W-1:0] wait_cnt,
    output logic              ready
);

    lk_state_e         st, st_nxt;
    logic [LOCK_W-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= LK_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        unique case (st)
            LK_OFF: begin
                cnt_nxt = '0;
                if (run) begin
                    if (wait_cnt == '0) begin
                        st_nxt = LK_READY;
                    end else begin
                        st_nxt  = LK_WAIT;
                        cnt_nxt = LOCK_W'(1);
                    end
                end
            end
            LK_WAIT: begin
                if (!run) begin
                    st_nxt = LK_OFF;
                end else if (cnt >= wait_cnt) begin
                    st_nxt = LK_READY;
                end else begin
                    cnt_nxt = cnt + LOCK_W'(1);
                end
            end
            LK_READY: begin
                if (!run) st_nxt = LK_OFF;
            end
            default: st_nxt = LK_OFF;
        endcase
    end

    always_comb begin
        ready = (st == LK_READY);
    end

    // R8: readiness only ever follows a running PLL
    a_r8_ready_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(run));

    // R8: stopping the PLL clears readiness one edge later
    a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !ready);

endmodule

// File: rtl/pm_ctl_pin.sv
module pm_ctl_pin
    import pm_pkg::*;
#(
    parameter  int NPLL   = 3,
    parameter  int NOUT   = 3,
    parameter  int LOCK_W = 16,
    localparam int SEL_W  = $clog2(NPLL + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_pin,
    input  logic [1:0]            cfg_mode,
    input  logic                  cfg_fs_susp,
    input  logic [NPLL-1:0]       cfg_susp_pll,
    input  logic [NOUT-1:0]       cfg_susp_out,
    input  logic [NOUT*SEL_W-1:0] cfg_route,
    input  logic [LOCK_W-1:0]     cfg_lock_wait,
    output logic [NOUT-1:0]       out_en,
    output logic [NPLL-1:0]       pll_run,
    output logic                  osc_en,
    output logic                  cnt_en,
    output logic                  fs_sel,
    output logic [NPLL-1:0]       pll_ready,
    output logic                  cfg_err
);

    pin_mode_e       mode;
    pm_state_e       st, st_nxt;
    logic            pin_s;
    logic            mask_err;
    logic            shut_req, oe_low, susp_req, pm_on;
    logic [NPLL-1:0] run_v, rdy_v;
    logic [NOUT-1:0] src_rdy;

    assign mode = pin_mode_e'(cfg_mode);

    pm_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ctl_pin),
        .dout (pin_s)
    );

    pm_mask_chk #(.NPLL(NPLL), .NOUT(NOUT), .SEL_W(SEL_W)) u_chk (
        .susp_pll(cfg_susp_pll),
        .susp_out(cfg_susp_out),
        .route   (cfg_route),
        .err     (mask_err)
    );

    // Pin role decode
    always_comb begin
        shut_req = (mode == PIN_SHUT) && !pin_s;
        oe_low   = (mode == PIN_OE) && !pin_s;
        susp_req = ((mode == PIN_SUSP) || ((mode == PIN_FS) && cfg_fs_susp))
                   && !pin_s && !mask_err;
    end

    // Power state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PM_ACTIVE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            PM_ACTIVE:   if (shut_req)  st_nxt = PM_SHUTDOWN;
            PM_SHUTDOWN: if (!shut_req) st_nxt = PM_ACTIVE;
            default:     st_nxt = PM_ACTIVE;
        endcase
    end

    // One lock timer per PLL
    for (genvar i = 0; i < NPLL; i++) begin : g_lock
        pm_lock_tmr #(.LOCK_W(LOCK_W)) u_lk (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run_v[i]),
            .wait_cnt(cfg_lock_wait),
            .ready   (rdy_v[i])
        );
    end

    // Outputs
    always_comb begin
        pm_on  = (st == PM_ACTIVE);
        osc_en = pm_on;
        cnt_en = pm_on;
        fs_sel = (mode == PIN_FS) && pin_s;
        for (int i = 0; i < NPLL; i++) begin
            run_v[i] = pm_on && !(susp_req && cfg_susp_pll[i]);
        end
        for (int j = 0; j < NOUT; j++) begin
            src_rdy[j] = 1'b1;
            for (int k = 0; k < NPLL; k++) begin
                if (cfg_route[j*SEL_W +: SEL_W] == SEL_W'(k + 1)) src_rdy[j] = rdy_v[k];
            end
            out_en[j] = pm_on && !oe_low && !(susp_req && cfg_susp_out[j]) && src_rdy[j];
        end
    end

    assign pll_run   = run_v;
    assign pll_ready = rdy_v;
    assign cfg_err   = mask_err;

    // R4: a held shutdown leaves no PLL ready
    a_r4_ready_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PM_SHUTDOWN) |=> (st != PM_SHUTDOWN || pll_ready == '0));

    // R7: a flagged mask never stops a PLL
    a_r7_err_keeps_plls: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && st == PM_ACTIVE) |-> (&pll_run));

    // R3: output-enable mode leaves the PLLs running
    a_r3_oe_keeps_plls: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PIN_OE && st == PM_ACTIVE) |-> (&pll_run));

    // R9: an enabled output never comes from an unready PLL
    for (genvar j = 0; j < NOUT; j++) begin : g_chk_out
        for (genvar k = 0; k < NPLL; k++) begin : g_chk_src
            a_r9_src_ready: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_route[j*SEL_W +: SEL_W] == SEL_W'(k + 1) && out_en[j]) |-> pll_ready[k]);
        end
    end

endmodule

// File: tb/sim_pm_ctl_pin.sv
`timescale 1ns/1ps
module sim_pm_ctl_pin;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_pin = 1'b1;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_fs_susp = 1'b0;
    logic [2:0]  cfg_susp_pll = 3'b000;
    logic [2:0]  cfg_susp_out = 3'b000;
    logic [5:0]  cfg_route = 6'b00_10_01;   // out0<-PLL1, out1<-PLL2, out2<-reference
    logic [15:0] cfg_lock_wait = 16'd4;
    logic [2:0]  out_en, pll_run, pll_ready;
    logic        osc_en, cnt_en, fs_sel, cfg_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pm_ctl_pin u0 (
        .clk(clk), .rst_n(rst_n), .ctl_pin(ctl_pin), .cfg_mode(cfg_mode),
        .cfg_fs_susp(cfg_fs_susp), .cfg_susp_pll(cfg_susp_pll),
        .cfg_susp_out(cfg_susp_out), .cfg_route(cfg_route),
        .cfg_lock_wait(cfg_lock_wait), .out_en(out_en), .pll_run(pll_run),
        .osc_en(osc_en), .cnt_en(cnt_en), .fs_sel(fs_sel),
        .pll_ready(pll_ready), .cfg_err(cfg_err)
    );

    // Reference model state
    bit m_s1 = 1'b1, m_s2 = 1'b1, m_shut = 1'b0;
    int m_cnt[3] = '{0, 0, 0};

    function automatic bit f_err();
        for (int j = 0; j < 3; j++) begin
            int r = int'(cfg_route[j*2 +: 2]);
            if (r != 0 && cfg_susp_pll[r-1] && !cfg_susp_out[j]) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic bit f_susp();
        return (cfg_mode == 2'd1 || (cfg_mode == 2'd0 && cfg_fs_susp)) && !m_s2 && !f_err();
    endfunction

    function automatic logic [2:0] f_run();
        logic [2:0] v;
        for (int i = 0; i < 3; i++) v[i] = !m_shut && !(f_susp() && cfg_susp_pll[i]);
        return v;
    endfunction

    function automatic logic [2:0] f_ready();
        logic [2:0] v;
        for (int i = 0; i < 3; i++) v[i] = (m_cnt[i] >= int'(cfg_lock_wait) + 1);
        return v;
    endfunction

    function automatic logic [2:0] f_out();
        logic [2:0] v;
        logic [2:0] rd = f_ready();
        for (int j = 0; j < 3; j++) begin
            int r = int'(cfg_route[j*2 +: 2]);
            v[j] = !m_shut && !(cfg_mode == 2'd2 && !m_s2)
                   && !(f_susp() && cfg_susp_out[j]) && (r == 0 || rd[r-1]);
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1'b1; m_s2 = 1'b1; m_shut = 1'b0;
            for (int i = 0; i < 3; i++) m_cnt[i] = 0;
        end else begin
            logic [2:0] r;
            bit sreq;
            r = f_run();
            sreq = (cfg_mode == 2'd3) && !m_s2;
            for (int i = 0; i < 3; i++)
                m_cnt[i] = r[i] ? ((m_cnt[i] < 1000000) ? m_cnt[i] + 1 : m_cnt[i]) : 0;
            m_shut = sreq;
            m_s2 = m_s1;
            m_s1 = ctl_pin;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!done) begin
            chk("R9", "out_en", 32'(out_en), 32'(f_out()));
            chk("R5", "pll_run", 32'(pll_run), 32'(f_run()));
            chk("R8", "pll_ready", 32'(pll_ready), 32'(f_ready()));
            chk("R4", "osc_en", 32'(osc_en), 32'(!m_shut));
            chk("R4", "cnt_en", 32'(cnt_en), 32'(!m_shut));
            chk("R2", "fs_sel", 32'(fs_sel), 32'(cfg_mode == 2'd0 && m_s2));
            chk("R7", "cfg_err", 32'(cfg_err), 32'(f_err()));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        step(3); #1;
        chk("R10", "ready in reset", 32'(pll_ready), 32'h0);
        chk("R10", "osc in reset", 32'(osc_en), 32'h1);
        step(1); rst_n = 1'b1;
        step(4); #1;
        chk("R9", "ref output before lock", 32'(out_en), 32'h4);
        chk("R8", "not ready at W edges", 32'(pll_ready), 32'h0);
        step(1); #1;
        chk("R8", "ready at W+1 edges", 32'(pll_ready), 32'h7);
        chk("R2", "fs level high", 32'(fs_sel), 32'h1);
        // R1 latency
        step(1); ctl_pin = 1'b0;
        step(1); #1;
        chk("R1", "fs after one edge", 32'(fs_sel), 32'h1);
        step(1); #1;
        chk("R1", "fs after two edges", 32'(fs_sel), 32'h0);
        step(1); ctl_pin = 1'b1;
        step(3);
        // R5 suspend with legal mask
        cfg_mode = 2'd1; cfg_susp_pll = 3'b010; cfg_susp_out = 3'b010; ctl_pin = 1'b0;
        step(2); #1;
        chk("R5", "suspend run", 32'(pll_run), 32'h5);
        chk("R5", "suspend out", 32'(out_en), 32'h5);
        step(1); ctl_pin = 1'b1;
        step(2); #1;
        chk("R8", "resumed pll relocks", 32'(pll_ready), 32'h5);
        chk("R9", "output waits for relock", 32'(out_en), 32'h5);
        step(6);
        // R7 illegal mask
        cfg_susp_out = 3'b000; #1;
        chk("R7", "error flag", 32'(cfg_err), 32'h1);
        step(1); ctl_pin = 1'b0;
        step(3); #1;
        chk("R7", "mask ignored run", 32'(pll_run), 32'h7);
        chk("R7", "mask ignored out", 32'(out_en), 32'h7);
        step(1); ctl_pin = 1'b1; cfg_susp_out = 3'b010;
        step(3);
        // R6 FS plus suspend
        cfg_mode = 2'd0; cfg_fs_susp = 1'b1; ctl_pin = 1'b0;
        step(2); #1;
        chk("R6", "fs low", 32'(fs_sel), 32'h0);
        chk("R6", "suspend in fs mode", 32'(pll_run), 32'h5);
        step(1); ctl_pin = 1'b1; cfg_fs_susp = 1'b0;
        step(8);
        // R3 output enable
        cfg_mode = 2'd2; ctl_pin = 1'b0;
        step(2); #1;
        chk("R3", "outputs off", 32'(out_en), 32'h0);
        chk("R3", "plls kept", 32'(pll_run), 32'h7);
        step(1); ctl_pin = 1'b1;
        step(2); #1;
        chk("R3", "outputs back", 32'(out_en), 32'h7);
        // R4 shutdown and relock
        step(1); cfg_mode = 2'd3; ctl_pin = 1'b0;
        step(2); #1;
        chk("R4", "osc before state edge", 32'(osc_en), 32'h1);
        step(1); #1;
        chk("R4", "osc off", 32'(osc_en), 32'h0);
        chk("R4", "plls off", 32'(pll_run), 32'h0);
        chk("R4", "outputs off", 32'(out_en), 32'h0);
        step(1); #1;
        chk("R4", "ready cleared", 32'(pll_ready), 32'h0);
        step(1); ctl_pin = 1'b1;
        step(3); #1;
        chk("R4", "osc back", 32'(osc_en), 32'h1);
        chk("R9", "only ref output after release", 32'(out_en), 32'h4);
        step(4); #1;
        chk("R8", "still locking", 32'(pll_ready), 32'h0);
        step(1); #1;
        chk("R8", "relocked", 32'(pll_ready), 32'h7);
        chk("R9", "all outputs", 32'(out_en), 32'h7);
        step(2);
        finish_run();
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

endmodule